// File: doc/BRIEF.md
# Pipelined Shift and Multiply Side Unit

This unit sits beside a small processor core. It takes one operation per cycle on a simple issue port: valid, a two-bit operation code and two register operands. The unit runs one of four operations: logical left shift, logical right shift, arithmetic right shift or multiply. Each runs in a pipeline of fixed depth. When an operation finishes, its result lands in a result register that belongs only to that operation kind. Nothing goes back into the core's register file by itself.

To get a result, the core uses a separate read port. A two-bit select picks one of the four result registers and shows it at once on the read data output, so a move instruction can copy it into a general register. The unit has no interlock. Software must leave the stated number of cycles between an issue and the read of the matching result. The data width is a parameter, 16 bits by default. Both latencies are parameters too, and each must be at least 3.

Top module: `shiftMulUnit`

## Requirements
- R1: An issue with code 0 (left shift) puts `opA << opB` into result register 0. The write happens on the 3rd rising edge, counting the edge that samples the issue as the first.
- R2: An issue with code 1 (logical right shift) puts `opA >> opB` into result register 1, filling with zeros, on the 3rd rising edge counted the same way.
- R3: An issue with code 2 (arithmetic right shift) puts `opA >>> opB` into result register 2, copying the sign bit of `opA` into the vacated bits, on the 3rd rising edge counted the same way.
- R4: An issue with code 3 (multiply) puts the low `DataW` bits of `opA * opB` into result register 3 on the 6th rising edge counted the same way.
- R5: A shift uses only the low log2(`DataW`) bits of `opB` as its amount. The upper bits have no effect.
- R6: `readData` shows, in the same cycle, the result register whose index is on `readSel` (0 left shift, 1 logical right, 2 arithmetic right, 3 multiply).
- R7: While `issueValid` is low, changes on `issueOp`, `opA` and `opB` never change any result register.
- R8: Operations may be issued on consecutive cycles, of the same kind or of mixed kinds. Each one completes on its own, in issue order within its kind, and none is lost.
- R9: An active-low reset clears all four result registers and discards operations still in flight. An operation issued just before reset never appears afterwards.
- R10: A result register keeps its value until the next operation of its own kind completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | Operation present on the issue port this cycle |
| issueOp | input | 2 | Operation code: 0 left shift, 1 logical right, 2 arithmetic right, 3 multiply |
| opA | input | DataW | First operand (value to shift, or multiplicand) |
| opB | input | DataW | Second operand (shift amount, or multiplier) |
| readSel | input | 2 | Index of the result register to read |
| readData | output | DataW | Contents of the selected result register |

## Verification
There is only one read port, and each result register is overwritten by every later operation of its kind. That makes exact latency hard to observe: a result that arrives one edge early or late can hide behind its neighbours. The bench therefore streams a different operand pair on every cycle into one pipeline and reads that pipeline's register on every cycle. The pairing between issue index and read index then fixes the latency exactly. The sweep uses an 8-bit width, so shift amounts above 7 exercise the masking of the amount. Separate phases cover reset with an operation in flight, and cover operand changes while valid is low.

// File: rtl/smuPkg.sv
package smuPkg;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_SRA = 2'd2,
    OP_MUL = 2'd3
  } smuOp_e;

  localparam int NUM_RES = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic               shCapture;
    logic               mulCapture;
    logic [NUM_RES-1:0] wrEn;
  } smuStrobe_t;

endpackage

// File: rtl/smuCtrl.sv
module smuCtrl
  import smuPkg::*;
#(
  parameter int ShiftLat = 3,
  parameter int MulLat   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [1:0] issueOp,
  output smuStrobe_t strb
);

  localparam int ShDepth  = ShiftLat - 1;
  localparam int MulDepth = MulLat - 1;

  logic               isShift;
  logic               isMul;
  logic [ShDepth-1:0] shValid;
  logic [1:0]         shKind [ShDepth];
  logic [MulDepth-1:0] mulValid;

  assign isShift = issueValid && (issueOp != OP_MUL);
  assign isMul   = issueValid && (issueOp == OP_MUL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shValid  <= '0;
      mulValid <= '0;
      for (int j = 0; j < ShDepth; j++) shKind[j] <= 2'd0;
    end else begin
      shValid  <= {shValid[ShDepth-2:0], isShift};
      mulValid <= {mulValid[MulDepth-2:0], isMul};
      shKind[0] <= issueOp;
      for (int j = 1; j < ShDepth; j++) shKind[j] <= shKind[j-1];
    end
  end

  always_comb begin
    strb            = '0;
    strb.shCapture  = isShift;
    strb.mulCapture = isMul;
    if (shValid[ShDepth-1] && (shKind[ShDepth-1] != OP_MUL))
      strb.wrEn[shKind[ShDepth-1]] = 1'b1;
    strb.wrEn[OP_MUL] = mulValid[MulDepth-1];
  end

  // R8
  shift_wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrEn[2:0]));

  // R4
  mul_issue_tracked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueOp == OP_MUL) |=> mulValid[0]);

  // R7
  idle_no_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!shValid[0] && !mulValid[0]));

endmodule

// File: rtl/smuDatapath.sv
module smuDatapath
  import smuPkg::*;
#(
  parameter int DataW    = 16,
  parameter int ShiftLat = 3,
  parameter int MulLat   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  smuStrobe_t       strb,
  input  logic [1:0]       issueOp,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [1:0]       readSel,
  output logic [DataW-1:0] readData
);

  localparam int AmtW      = $clog2(DataW);
  localparam int ShStages  = ShiftLat - 2;
  localparam int MulStages = MulLat - 2;

  logic [DataW-1:0] shA;
  logic [AmtW-1:0]  shAmt;
  logic [1:0]       shOp;
  logic [DataW-1:0] shRes;
  logic [DataW-1:0] shPipe [ShStages];

  logic [DataW-1:0] mA;
  logic [DataW-1:0] mB;
  logic [DataW-1:0] mProd;
  logic [DataW-1:0] mulPipe [MulStages];

  logic [DataW-1:0] resReg [NUM_RES];

  // operand capture stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shA   <= '0;
      shAmt <= '0;
      shOp  <= 2'd0;
      mA    <= '0;
      mB    <= '0;
    end else begin
      if (strb.shCapture) begin
        shA   <= opA;
        shAmt <= opB[AmtW-1:0];
        shOp  <= issueOp;
      end
      if (strb.mulCapture) begin
        mA <= opA;
        mB <= opB;
      end
    end
  end

  always_comb begin
    case (shOp)
      OP_SHL:  shRes = shA << shAmt;
      OP_SHR:  shRes = shA >> shAmt;
      default: shRes = $signed(shA) >>> shAmt;
    endcase
  end

  assign mProd = mA * mB;

  // delay stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < ShStages; j++)  shPipe[j]  <= '0;
      for (int j = 0; j < MulStages; j++) mulPipe[j] <= '0;
    end else begin
      shPipe[0]  <= shRes;
      mulPipe[0] <= mProd;
      for (int j = 1; j < ShStages; j++)  shPipe[j]  <= shPipe[j-1];
      for (int j = 1; j < MulStages; j++) mulPipe[j] <= mulPipe[j-1];
    end
  end

  // result registers
  genvar gi;
  generate
    for (gi = 0; gi < NUM_RES; gi++) begin : g_res
      logic [DataW-1:0] wrVal;
      if (gi == OP_MUL) begin : g_mul
        assign wrVal = mulPipe[MulStages-1];
      end else begin : g_sh
        assign wrVal = shPipe[ShStages-1];
      end

      always_ff @(posedge clk) begin
        if (!rstN)              resReg[gi] <= '0;
        else if (strb.wrEn[gi]) resReg[gi] <= wrVal;
      end

      // R10
      res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strb.wrEn[gi] |=> $stable(resReg[gi]));
    end
  endgenerate

  assign readData = resReg[readSel];

endmodule

// File: rtl/shiftMulUnit.sv
module shiftMulUnit
  import smuPkg::*;
#(
  parameter int DataW    = 16,
  parameter int ShiftLat = 3,
  parameter int MulLat   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [1:0]       issueOp,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [1:0]       readSel,
  output logic [DataW-1:0] readData
);

  smuStrobe_t strb;

  smuCtrl #(.ShiftLat(ShiftLat), .MulLat(MulLat)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .strb       (strb)
  );

  smuDatapath #(.DataW(DataW), .ShiftLat(ShiftLat), .MulLat(MulLat)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .issueOp  (issueOp),
    .opA      (opA),
    .opB      (opB),
    .readSel  (readSel),
    .readData (readData)
  );

endmodule

// File: tb/shiftMulUnit_test.sv
module shiftMulUnit_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         issueValid;
  logic [1:0]   issueOp;
  logic [W-1:0] opA;
  logic [W-1:0] opB;
  logic [1:0]   readSel;
  logic [W-1:0] readData;

  int compared = 0;
  int mismatched = 0;

  shiftMulUnit #(.DataW(W), .ShiftLat(3), .MulLat(6)) uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .opA(opA), .opB(opB), .readSel(readSel), .readData(readData)
  );

  always #5 clk = ~clk;

  function automatic int latOf(input int kind);
    return (kind == 3) ? 6 : 3;
  endfunction

  function automatic int aOf(input int kind, input int j);
    return (j * 37 + kind * 11 + 5) % 256;
  endfunction

  function automatic int bOf(input int kind, input int j);
    if (kind == 3) return (j * 29 + 7) % 256;
    return j % 16;
  endfunction

  function automatic int expOf(input int kind, input int a, input int b);
    int amt;
    int sa;
    amt = b % 8;
    case (kind)
      0: return (a * (1 << amt)) % 256;
      1: return a / (1 << amt);
      2: begin
        sa = (a >= 128) ? a - 256 : a;
        sa = sa >>> amt;
        return (sa + 256) % 256;
      end
      default: return (a * b) % 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readAt(input int sel, output int val);
    readSel = sel[1:0];
    #1;
    val = int'(readData);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic streamKind(input int kind, input int n, input string req);
    int lat;
    int v;
    lat = latOf(kind);
    for (int j = 0; j < n + lat; j++) begin
      @(negedge clk);
      if (j >= lat) begin
        readAt(kind, v);
        check(req, v, expOf(kind, aOf(kind, j - lat), bOf(kind, j - lat)));
      end
      if (j < n) begin
        issueValid = 1'b1;
        issueOp    = kind[1:0];
        opA        = aOf(kind, j)[W-1:0];
        opB        = bOf(kind, j)[W-1:0];
      end else begin
        issueValid = 1'b0;
      end
    end
  endtask

  task automatic issueOne(input int kind, input int a, input int b);
    @(negedge clk);
    issueValid = 1'b1;
    issueOp    = kind[1:0];
    opA        = a[W-1:0];
    opB        = b[W-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int v;
    int held [4];
    rstN = 1'b0; issueValid = 1'b0; issueOp = 2'd0;
    opA = '0; opB = '0; readSel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    for (int k = 0; k < 4; k++) begin
      readAt(k, v);
      check("R9 reset", v, 0);
    end

    // R1 R2 R3 R5 R4 R6 R8: back-to-back streams per kind
    streamKind(0, 256, "R1,R5,R6,R8");
    streamKind(1, 256, "R2,R5,R6,R8");
    streamKind(2, 256, "R3,R5,R6,R8");
    streamKind(3, 300, "R4,R6,R8");

    // R4 corner: full-scale product
    issueOne(3, 255, 255);
    @(negedge clk); issueValid = 1'b0;
    repeat (5) @(negedge clk);
    readAt(3, v);
    check("R4 max", v, 1);

    // R8 mixed kinds on consecutive cycles
    issueOne(0, 8'h96, 3);
    issueOne(1, 8'h96, 9);
    issueOne(2, 8'h96, 12);
    issueOne(3, 8'h96, 8'h0d);
    @(negedge clk); issueValid = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      readAt(k, v);
      held[k] = v;
    end
    check("R8 mixed sl", held[0], expOf(0, 8'h96, 3));
    check("R8 mixed sr", held[1], expOf(1, 8'h96, 9));
    check("R8 mixed sra", held[2], expOf(2, 8'h96, 12));
    check("R8 mixed mul", held[3], expOf(3, 8'h96, 8'h0d));

    // R7 R10: operands move while valid is low
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      issueValid = 1'b0;
      issueOp = j[1:0];
      opA = (j * 53 + 1) % 256;
      opB = (j * 17 + 2) % 256;
    end
    repeat (7) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      readAt(k, v);
      check("R7,R10 idle", v, held[k]);
    end

    // R9: in-flight operations discarded by reset
    issueOne(3, 7, 9);
    issueOne(0, 5, 1);
    @(negedge clk);
    issueValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      readAt(k, v);
      check("R9 flush", v, 0);
    end

    summary();
  end

endmodule